// File: doc/BRIEF.md
# Clocked Serial Shift Transmitter

This block is the transmit side of a synchronous serial link. The host loads one byte through a single-cycle write strobe. The block then sends the eight bits on one data line, least significant bit first. A mode input picks how bits are timed. In internal-clock mode the block makes its own shift clock from the system clock and drives it out. In external-clock mode it follows a clock from the link partner, and a select input chooses which edge of that clock is active.

When the byte is done, a sticky completion flag is set and a one-cycle interrupt request is pulsed. The host clears the flag with a clear strobe, or implicitly by loading the next byte. A write that arrives while a byte is still going out is dropped and sets a sticky overrun flag. While a byte is in flight the block reports busy. When idle, the data line keeps the last bit it sent.

Top module: `sync_ser_tx`

## Requirements
- R1: After synchronous reset, txd is 1, sclk_out is 1, and busy, done_flag, ovr_flag and tx_irq are 0.
- R2: In internal mode, a write accepted at clock edge E0 drives wr_data bit 0 on txd after E0. Bit j (0..7) is on txd from edge E0+2jH to edge E0+2(j+1)H, where H = half_cfg+1. busy is 1 throughout.
- R3: In internal mode, sclk_out is 0 in the first H cycles of each bit and 1 in the last H cycles, giving 8 rising edges per byte. sclk_out is 1 whenever the block is idle.
- R4: In internal mode, at edge E0+16H busy falls, done_flag is set and tx_irq is 1 for exactly one cycle. txd holds bit 7 and sclk_out stays 1.
- R5: In external mode with no accepted write, ext_sclk activity leaves txd, busy and done_flag unchanged.
- R6: In external mode, edge_sel=0 makes the rising edge of ext_sclk active and edge_sel=1 the falling edge. After an accepted write, txd does not change until an active edge. The k-th active edge (k=1..8) drives bit k-1. Each edge takes effect on the third system clock edge after ext_sclk changes, because of a two-flop synchronizer plus edge detection.
- R7: In external mode, the first inactive edge after the eighth active edge ends the byte. busy falls, done_flag is set and tx_irq pulses for one cycle. Before that edge, busy stays 1 and done_flag stays 0.
- R8: A write while busy is ignored. The byte in flight continues unchanged, and ovr_flag is 1 from the next cycle.
- R9: done_flag is cleared one cycle after a clr_done strobe or after an accepted write. ovr_flag is cleared one cycle after a clr_ovr strobe.
- R10: While idle, txd holds the last bit sent.
- R11: In external mode sclk_out stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the transmit buffer |
| wr_data | input | DATA_W | Byte to transmit |
| clr_done | input | 1 | Clears the completion flag (write-one-to-clear) |
| clr_ovr | input | 1 | Clears the overrun flag |
| ext_mode | input | 1 | 0: internal shift clock, 1: external shift clock; sampled at write |
| edge_sel | input | 1 | Active external edge: 0 rising, 1 falling |
| half_cfg | input | DIV_W | Internal shift clock half period minus one, in system cycles |
| ext_sclk | input | 1 | Shift clock from the link partner |
| sclk_out | output | 1 | Generated shift clock, idles high |
| txd | output | 1 | Serial data out, LSB first |
| busy | output | 1 | Byte being shifted |
| done_flag | output | 1 | Sticky completion flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| tx_irq | output | 1 | One-cycle transmit interrupt request |

## Verification
Internal-mode results are due at fixed offsets from the write edge. The first bit is due one edge after the write, each clock level lasts H cycles, and the finish comes at 16H cycles. The bench therefore counts sample points from the write and checks txd and sclk_out on every cycle of the byte. External-mode results land on the third system edge after each ext_sclk change. The bench holds each ext_sclk level for four cycles and samples after the level has settled. For the finish, it samples exactly three cycles after the closing edge to catch the one-cycle interrupt, then one cycle later to see it drop. All samples are taken on the falling system clock edge, between the edges that update the outputs.

// File: rtl/sst_pkg.sv
package sst_pkg;
  typedef enum logic {PH_LOW = 1'b0, PH_HIGH = 1'b1} sclk_phase_t;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/sst_edge_sync.sv
module sst_edge_sync
  import sst_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  input  logic edge_sel,
  output logic act_edge,
  output logic inact_edge
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  always_comb begin
    act_edge   = edge_sel ? fall : rise;
    inact_edge = edge_sel ? rise : fall;
  end
endmodule

// File: rtl/sst_clkgen.sv
module sst_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_comb tick = run && !restart && (cnt_q == half_cfg);

  always_ff @(posedge clk) begin
    if (rst || restart)  cnt_q <= '0;
    else if (run) begin
      if (cnt_q == half_cfg) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] start_data,
  input  logic              start_ext,
  input  logic              tick,
  input  logic              act_edge,
  input  logic              inact_edge,
  output logic              txd,
  output logic              sclk,
  output logic              busy,
  output logic              ext_q,
  output logic              fin
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sreg_q;
  logic [CNT_W-1:0]  sent_q;
  sclk_phase_t       phase_q;
  logic              all_out;

  assign all_out = (sent_q == LAST);

  always_comb begin
    if (!busy)       fin = 1'b0;
    else if (ext_q)  fin = inact_edge && all_out;
    else             fin = tick && (phase_q == PH_HIGH) && all_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg_q  <= '0;
      sent_q  <= '0;
      phase_q <= PH_HIGH;
      txd     <= 1'b1;
      sclk    <= 1'b1;
      busy    <= 1'b0;
      ext_q   <= 1'b0;
    end else if (start) begin
      busy  <= 1'b1;
      ext_q <= start_ext;
      sclk  <= 1'b1;
      if (start_ext) begin
        sreg_q  <= start_data;
        sent_q  <= '0;
        phase_q <= PH_HIGH;
      end else begin
        txd     <= start_data[0];
        sreg_q  <= start_data >> 1;
        sent_q  <= CNT_W'(1);
        phase_q <= PH_LOW;
        sclk    <= 1'b0;
      end
    end else if (busy) begin
      if (fin) begin
        busy <= 1'b0;
        sclk <= 1'b1;
      end else if (ext_q) begin
        if (act_edge && !all_out) begin
          txd    <= sreg_q[0];
          sreg_q <= sreg_q >> 1;
          sent_q <= sent_q + 1'b1;
        end
      end else if (tick) begin
        if (phase_q == PH_LOW) begin
          sclk    <= 1'b1;
          phase_q <= PH_HIGH;
        end else begin
          sclk    <= 1'b0;
          phase_q <= PH_LOW;
          txd     <= sreg_q[0];
          sreg_q  <= sreg_q >> 1;
          sent_q  <= sent_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr_done,
  input  logic              clr_ovr,
  input  logic              ext_mode,
  input  logic              edge_sel,
  input  logic [DIV_W-1:0]  half_cfg,
  input  logic              ext_sclk,
  output logic              sclk_out,
  output logic              txd,
  output logic              busy,
  output logic              done_flag,
  output logic              ovr_flag,
  output logic              tx_irq
);
  logic accept, tick, act_edge, inact_edge, ext_q, fin;

  assign accept = wr_en && !busy;

  sst_edge_sync u_sync (
    .clk        (clk),
    .rst        (rst),
    .async_in   (ext_sclk),
    .edge_sel   (edge_sel),
    .act_edge   (act_edge),
    .inact_edge (inact_edge)
  );

  sst_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .restart  (accept),
    .run      (busy && !ext_q),
    .half_cfg (half_cfg),
    .tick     (tick)
  );

  sst_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_data (wr_data),
    .start_ext  (ext_mode),
    .tick       (tick),
    .act_edge   (act_edge),
    .inact_edge (inact_edge),
    .txd        (txd),
    .sclk       (sclk_out),
    .busy       (busy),
    .ext_q      (ext_q),
    .fin        (fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      done_flag <= 1'b0;
      ovr_flag  <= 1'b0;
      tx_irq    <= 1'b0;
    end else begin
      tx_irq <= fin && !done_flag;
      if (fin)                      done_flag <= 1'b1;
      else if (accept || clr_done)  done_flag <= 1'b0;
      if (wr_en && busy)            ovr_flag  <= 1'b1;
      else if (clr_ovr)             ovr_flag  <= 1'b0;
    end
  end
endmodule

// File: rtl/sst_checker.sv
module sst_checker (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic busy,
  input logic txd,
  input logic sclk_out,
  input logic done_flag,
  input logic ovr_flag,
  input logic tx_irq
);
  p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
    tx_irq |=> !tx_irq);
  p_irq_with_flag_r4: assert property (@(posedge clk) disable iff (rst)
    tx_irq |-> (done_flag && !busy));
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sclk_out);
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> $stable(txd));
  p_overrun_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy) |=> ovr_flag);
  p_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !busy) |=> (!done_flag && busy));
endmodule

bind sync_ser_tx sst_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .busy      (busy),
  .txd       (txd),
  .sclk_out  (sclk_out),
  .done_flag (done_flag),
  .ovr_flag  (ovr_flag),
  .tx_irq    (tx_irq)
);

// File: tb/sync_ser_tx_tb_top.sv
module sync_ser_tx_tb_top;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int WD_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic clr_done = 1'b0, clr_ovr = 1'b0, ext_mode = 1'b0, edge_sel = 1'b0;
  logic [DIV_W-1:0] half_cfg = '0;
  logic ext_sclk = 1'b0;
  logic sclk_out, txd, busy, done_flag, ovr_flag, tx_irq;

  int total = 0;
  int bad = 0;

  always #(CLK_P/2) clk = ~clk;

  sync_ser_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .clr_done(clr_done), .clr_ovr(clr_ovr), .ext_mode(ext_mode),
    .edge_sel(edge_sel), .half_cfg(half_cfg), .ext_sclk(ext_sclk),
    .sclk_out(sclk_out), .txd(txd), .busy(busy), .done_flag(done_flag),
    .ovr_flag(ovr_flag), .tx_irq(tx_irq)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 txd", txd, 1);
    chk("R1 sclk_out", sclk_out, 1);
    chk("R1 busy", busy, 0);
    chk("R1 done_flag", done_flag, 0);
    chk("R1 ovr_flag", ovr_flag, 0);
    chk("R1 tx_irq", tx_irq, 0);
  endtask

  task automatic t_int_byte(input logic [7:0] data, input int half, input bit inj);
    int h;
    h = half + 1;
    @(negedge clk);
    ext_mode = 1'b0;
    half_cfg = DIV_W'(half);
    wr_data  = data;
    wr_en    = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk("R9 done cleared by write", done_flag, 0);
    for (int k = 0; k < 16*h; k++) begin
      chk("R2 txd bit", txd, data[k/(2*h)]);
      chk("R3 sclk level", sclk_out, (k/h) % 2);
      chk("R2 busy", busy, 1);
      if (inj && k == 3) begin
        wr_en   = 1'b1;
        wr_data = ~data;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    chk("R4 busy low", busy, 0);
    chk("R4 done set", done_flag, 1);
    chk("R4 irq pulse", tx_irq, 1);
    chk("R4 sclk high", sclk_out, 1);
    chk("R4 txd bit7", txd, data[7]);
    if (inj) chk("R8 overrun set", ovr_flag, 1);
    @(negedge clk);
    chk("R4 irq one cycle", tx_irq, 0);
    chk("R4 done sticky", done_flag, 1);
  endtask

  task automatic t_idle_hold(input logic exp_bit);
    repeat (6) @(negedge clk);
    chk("R10 txd holds last bit", txd, exp_bit);
    chk("R3 sclk idle high", sclk_out, 1);
  endtask

  task automatic t_clear_done();
    @(negedge clk);
    clr_done = 1'b1;
    @(negedge clk);
    clr_done = 1'b0;
    chk("R9 clr_done", done_flag, 0);
  endtask

  task automatic t_clear_ovr();
    @(negedge clk);
    clr_ovr = 1'b1;
    @(negedge clk);
    clr_ovr = 1'b0;
    chk("R9 clr_ovr", ovr_flag, 0);
  endtask

  task automatic t_ext_idle();
    logic hold;
    @(negedge clk);
    ext_mode = 1'b1;
    edge_sel = 1'b0;
    hold = txd;
    for (int n = 0; n < 6; n++) begin
      ext_sclk = ~ext_sclk;
      repeat (4) @(negedge clk);
      chk("R5 txd unchanged", txd, hold);
      chk("R5 busy idle", busy, 0);
      chk("R5 done unchanged", done_flag, 0);
      chk("R11 sclk_out high", sclk_out, 1);
    end
  endtask

  task automatic t_ext_byte(input logic [7:0] data, input logic es);
    logic hold;
    @(negedge clk);
    ext_mode = 1'b1;
    edge_sel = es;
    ext_sclk = es;
    repeat (5) @(negedge clk);
    hold    = txd;
    wr_data = data;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R6 busy after write", busy, 1);
    chk("R6 txd waits for edge", txd, hold);
    for (int j = 0; j < 8; j++) begin
      ext_sclk = ~es;
      repeat (4) @(negedge clk);
      chk("R6 txd on active edge", txd, data[j]);
      chk("R11 sclk_out high", sclk_out, 1);
      ext_sclk = es;
      if (j < 7) begin
        repeat (4) @(negedge clk);
        chk("R7 busy held", busy, 1);
        chk("R6 txd stable on inactive edge", txd, data[j]);
      end else begin
        repeat (3) @(negedge clk);
        chk("R7 irq on closing edge", tx_irq, 1);
        chk("R7 done set", done_flag, 1);
        chk("R7 busy low", busy, 0);
        @(negedge clk);
        chk("R7 irq one cycle", tx_irq, 0);
      end
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_int_byte(8'h35, 0, 1'b0);
    t_idle_hold(1'b0);
    t_int_byte(8'hCA, 2, 1'b0);
    t_idle_hold(1'b1);
    t_clear_done();
    t_int_byte(8'h5B, 1, 1'b1);
    t_clear_ovr();
    t_clear_done();
    t_ext_idle();
    t_ext_byte(8'h96, 1'b0);
    t_idle_hold(1'b1);
    t_ext_byte(8'h3C, 1'b1);
    t_idle_hold(1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule